// File: doc/BRIEF.md
# Control Word Insertion Table

This block keeps two tables of control words, one for the transmit direction and one for the receive direction. Each table has one entry for every control-word slot of a hyperframe. The transmit side counts control-word slots and may swap the word arriving from upstream for the stored entry of that slot. The swap happens only when both the entry's own insert flag and a global insert enable are set. The receive side counts its own slots and stores every incoming control word into the entry for that slot.

Software never addresses the tables directly. It works through a pointer register that holds an entry number and a 32-bit section number. Two data windows then show the selected section: one can be written and holds transmit data, the other holds received data and is read-only. The pointer register also carries the insert flag of the entry it points to. A configuration register holds the global insert enable and a clocking-mode bit, which leaves the block on a port for the clocking logic.

The bus is synchronous: an address, a write strobe, write data and a read-data register. Byte offsets are 0x08 for configuration, 0x0C for the pointer, 0x10 for the transmit-data window and 0x14 for the receive-data window.

Top module: `ctrl_word_table`

## Requirements
- R1: After reset the configuration register reads as 0x0000_0000 (insert enable 0, mode bit equal to parameter SLAVE_RST, default 0). The pointer register reads as 0x0000_0000, and every insert flag is 0. With only the global enable set, no slot is replaced.
- R2: In the configuration register at 0x08, bit 0 is the global insert enable and bit 1 the clocking mode (0 master, 1 slave). The mode bit drives `clk_mode_slave`. All other bits read as zero.
- R3: In the pointer register at 0x0C, bits [7:0] hold the entry number and bits [9:8] the section number. Bits [31:17] and [15:10] read as zero and ignore writes.
- R4: Bit 16 of the pointer register reads as the insert flag of the entry being pointed to. A write whose entry number equals the current one stores bit 16 into that entry's flag. A write that changes the entry number moves the pointer and leaves every flag unchanged.
- R5: A write to 0x10 replaces only the selected 32-bit section of the selected transmit entry, with section n at bits [32n+31:32n]. A read of 0x10 returns that section.
- R6: Every transmit slot (`tx_valid_in` high) produces `tx_valid_out` one cycle later. If the slot's entry flag and the global enable are both 1, `tx_word_out` carries that entry. Between slots `tx_word_out` holds its value.
- R7: If the flag or the global enable is 0, `tx_word_out` is the upstream word of that slot, unchanged.
- R8: The slot number is 0 on a slot with the hyperframe-start input set. Otherwise it is one more than that of the previous slot and wraps from 255 to 0. Cycles without a slot do not advance it. The transmit and receive sides count separately.
- R9: Each receive slot stores the full incoming word into the receive entry of its slot number. The stored word is readable section by section at 0x14.
- R10: Read data appears on `bus_rdata` one cycle after the address. A read of the receive entry in the same cycle as a capture into that entry returns the value from before the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| clk_mode_slave | output | 1 | Clocking mode bit (1 slave, 0 master) |
| tx_valid_in | input | 1 | Transmit control-word slot present |
| tx_hf_start | input | 1 | This transmit slot is slot 0 |
| tx_word_in | input | WORD_W (128) | Upstream control word |
| tx_valid_out | output | 1 | Outgoing slot present |
| tx_word_out | output | WORD_W (128) | Outgoing control word |
| rx_valid | input | 1 | Receive control-word slot present |
| rx_hf_start | input | 1 | This receive slot is slot 0 |
| rx_word | input | WORD_W (128) | Incoming control word |

## Verification
The hardest case is a slot counter that has wrapped past 255. Reaching it takes a long run of slots with idle cycles between them, so the bench streams 257 slots. It then checks the replace-or-pass decision of every slot against its own flag model, including the second visit to slot 0. The read-during-capture case needs the pointer, the read address and a receive capture all set up on one edge. The bench arranges this and checks both the old value and, one cycle later, the new one.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
    localparam int unsigned SEC_W     = 32;
    localparam int unsigned SEC_SEL_W = 2;
    localparam int unsigned OFF_CFG   = 'h08;
    localparam int unsigned OFF_PTR   = 'h0C;
    localparam int unsigned OFF_TXD   = 'h10;
    localparam int unsigned OFF_RXD   = 'h14;
    localparam int unsigned FLAG_BIT  = 16;
endpackage

// File: rtl/cwt_slot_counter.sv
module cwt_slot_counter #(
    parameter int unsigned N_ENTRIES = 256,
    localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             start,
    output logic [IDX_W-1:0] slot
);
    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        slot  = start ? '0 : cnt_q;
        cnt_d = cnt_q;
        if (valid) begin
            cnt_d = (slot == IDX_W'(N_ENTRIES - 1)) ? '0 : slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start && cnt_q != IDX_W'(N_ENTRIES - 1)) |=> cnt_q == IDX_W'($past(cnt_q) + 1'b1)); // R8
    AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cnt_q)); // R8
    AST_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start) |=> cnt_q == IDX_W'(1)); // R8
endmodule

// File: rtl/cwt_table.sv
module cwt_table #(
    parameter int unsigned N_ENTRIES = 256,
    parameter int unsigned WORD_W    = 128,
    parameter int unsigned N_RD      = 1,
    localparam int unsigned IDX_W = $clog2(N_ENTRIES),
    localparam int unsigned N_SEC = WORD_W / cwt_pkg::SEC_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N_SEC-1:0]  wr_mask,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx  [N_RD],
    output logic [WORD_W-1:0] rd_word [N_RD]
);
    localparam int unsigned SW = cwt_pkg::SEC_W;

    logic [WORD_W-1:0] mem [N_ENTRIES];

    always_ff @(posedge clk) begin
        for (int g = 0; g < int'(N_SEC); g++) begin
            if (wr_en && wr_mask[g]) begin
                mem[wr_idx][g*SW +: SW] <= wr_data[g*SW +: SW];
            end
        end
    end

    for (genvar r = 0; r < int'(N_RD); r++) begin : g_rd
        assign rd_word[r] = mem[rd_idx[r]];
    end
endmodule

// File: rtl/cwt_regs.sv
module cwt_regs #(
    parameter int unsigned N_ENTRIES = 256,
    parameter int unsigned WORD_W    = 128,
    parameter int unsigned ADDR_W    = 8,
    parameter bit          SLAVE_RST = 1'b0,
    localparam int unsigned IDX_W = $clog2(N_ENTRIES),
    localparam int unsigned N_SEC = WORD_W / cwt_pkg::SEC_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [WORD_W-1:0]              tx_sw_word,
    input  logic [WORD_W-1:0]              rx_sw_word,
    output logic                           ins_en,
    output logic                           mode_slave,
    output logic [IDX_W-1:0]               ptr_idx,
    output logic [cwt_pkg::SEC_SEL_W-1:0]  ptr_sec,
    output logic [N_ENTRIES-1:0]           flags,
    output logic                           txd_we
);
    import cwt_pkg::*;

    typedef struct packed {
        logic                  ins_en;
        logic                  slave;
        logic [IDX_W-1:0]      idx;
        logic [SEC_SEL_W-1:0]  sec;
        logic [N_ENTRIES-1:0]  flags;
        logic [31:0]           rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit_cfg, hit_ptr, hit_txd, hit_rxd;
    logic [31:0] rd_val;

    always_comb begin
        hit_cfg = bus_addr == ADDR_W'(OFF_CFG);
        hit_ptr = bus_addr == ADDR_W'(OFF_PTR);
        hit_txd = bus_addr == ADDR_W'(OFF_TXD);
        hit_rxd = bus_addr == ADDR_W'(OFF_RXD);
        txd_we  = bus_we && hit_txd;

        rd_val = '0;
        if (hit_cfg) begin
            rd_val[0] = st_q.ins_en;
            rd_val[1] = st_q.slave;
        end else if (hit_ptr) begin
            rd_val[IDX_W-1:0]  = st_q.idx;
            rd_val[9:8]        = st_q.sec;
            rd_val[FLAG_BIT]   = st_q.flags[st_q.idx];
        end else if (hit_txd && int'(st_q.sec) < int'(N_SEC)) begin
            rd_val = tx_sw_word[st_q.sec*SEC_W +: SEC_W];
        end else if (hit_rxd && int'(st_q.sec) < int'(N_SEC)) begin
            rd_val = rx_sw_word[st_q.sec*SEC_W +: SEC_W];
        end

        st_d       = st_q;
        st_d.rdata = rd_val;
        if (bus_we && hit_cfg) begin
            st_d.ins_en = bus_wdata[0];
            st_d.slave  = bus_wdata[1];
        end
        if (bus_we && hit_ptr) begin
            if (bus_wdata[IDX_W-1:0] == st_q.idx) begin
                st_d.flags[st_q.idx] = bus_wdata[FLAG_BIT];
            end
            st_d.idx = bus_wdata[IDX_W-1:0];
            st_d.sec = bus_wdata[9:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.slave <= SLAVE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign ins_en     = st_q.ins_en;
    assign mode_slave = st_q.slave;
    assign ptr_idx    = st_q.idx;
    assign ptr_sec    = st_q.sec;
    assign flags      = st_q.flags;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ptr && bus_wdata[IDX_W-1:0] != st_q.idx) |=> flags == $past(flags)); // R4
    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_cfg) |=> (ins_en == $past(bus_wdata[0]) && mode_slave == $past(bus_wdata[1]))); // R2
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && hit_ptr) |=> $stable(flags)); // R4
endmodule

// File: rtl/ctrl_word_table.sv
module ctrl_word_table #(
    parameter int unsigned N_ENTRIES = 256,
    parameter int unsigned WORD_W    = 128,
    parameter int unsigned ADDR_W    = 8,
    parameter bit          SLAVE_RST = 1'b0,
    localparam int unsigned IDX_W = $clog2(N_ENTRIES),
    localparam int unsigned N_SEC = WORD_W / cwt_pkg::SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              clk_mode_slave,
    input  logic              tx_valid_in,
    input  logic              tx_hf_start,
    input  logic [WORD_W-1:0] tx_word_in,
    output logic              tx_valid_out,
    output logic [WORD_W-1:0] tx_word_out,
    input  logic              rx_valid,
    input  logic              rx_hf_start,
    input  logic [WORD_W-1:0] rx_word
);
    import cwt_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } txo_t;

    logic                  ins_en;
    logic [IDX_W-1:0]      ptr_idx;
    logic [SEC_SEL_W-1:0]  ptr_sec;
    logic [N_ENTRIES-1:0]  flags;
    logic                  txd_we;
    logic [IDX_W-1:0]      tx_slot, rx_slot;
    logic [N_SEC-1:0]      sec_mask;
    logic [IDX_W-1:0]      tx_rd_idx  [2];
    logic [WORD_W-1:0]     tx_rd_word [2];
    logic [IDX_W-1:0]      rx_rd_idx  [1];
    logic [WORD_W-1:0]     rx_rd_word [1];
    txo_t                  txo_d, txo_q;

    cwt_regs #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLAVE_RST(SLAVE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_sw_word(tx_rd_word[1]), .rx_sw_word(rx_rd_word[0]),
        .ins_en(ins_en), .mode_slave(clk_mode_slave), .ptr_idx(ptr_idx),
        .ptr_sec(ptr_sec), .flags(flags), .txd_we(txd_we)
    );

    cwt_slot_counter #(.N_ENTRIES(N_ENTRIES)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .valid(tx_valid_in), .start(tx_hf_start), .slot(tx_slot)
    );

    cwt_slot_counter #(.N_ENTRIES(N_ENTRIES)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .valid(rx_valid), .start(rx_hf_start), .slot(rx_slot)
    );

    for (genvar g = 0; g < int'(N_SEC); g++) begin : g_mask
        assign sec_mask[g] = int'(ptr_sec) == g;
    end

    assign tx_rd_idx[0] = tx_slot;
    assign tx_rd_idx[1] = ptr_idx;
    assign rx_rd_idx[0] = ptr_idx;

    cwt_table #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W), .N_RD(2)) u_tx_tbl (
        .clk(clk), .wr_en(txd_we), .wr_idx(ptr_idx), .wr_mask(sec_mask),
        .wr_data({N_SEC{bus_wdata}}), .rd_idx(tx_rd_idx), .rd_word(tx_rd_word)
    );

    cwt_table #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W), .N_RD(1)) u_rx_tbl (
        .clk(clk), .wr_en(rx_valid), .wr_idx(rx_slot), .wr_mask({N_SEC{1'b1}}),
        .wr_data(rx_word), .rd_idx(rx_rd_idx), .rd_word(rx_rd_word)
    );

    always_comb begin
        txo_d     = txo_q;
        txo_d.vld = tx_valid_in;
        if (tx_valid_in) begin
            txo_d.word = (ins_en && flags[tx_slot]) ? tx_rd_word[0] : tx_word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txo_q <= '0;
        else        txo_q <= txo_d;
    end

    assign tx_valid_out = txo_q.vld;
    assign tx_word_out  = txo_q.word;

    AST_TX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_in |=> tx_valid_out); // R6
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid_in |=> $stable(tx_word_out)); // R6
    AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_in && !ins_en) |=> tx_word_out == $past(tx_word_in)); // R7
endmodule

// File: tb/sim_ctrl_word_table.sv
module sim_ctrl_word_table;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 256;
    localparam int WW = 128;
    localparam logic [7:0] A_CFG = 8'h08, A_PTR = 8'h0C, A_TXD = 8'h10, A_RXD = 8'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          clk_mode_slave;
    logic          tx_valid_in = 1'b0, tx_hf_start = 1'b0;
    logic [WW-1:0] tx_word_in = '0;
    logic          tx_valid_out;
    logic [WW-1:0] tx_word_out;
    logic          rx_valid = 1'b0, rx_hf_start = 1'b0;
    logic [WW-1:0] rx_word = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit flag_m [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_word_table u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_mode_slave(clk_mode_slave),
        .tx_valid_in(tx_valid_in), .tx_hf_start(tx_hf_start), .tx_word_in(tx_word_in),
        .tx_valid_out(tx_valid_out), .tx_word_out(tx_word_out),
        .rx_valid(rx_valid), .rx_hf_start(rx_hf_start), .rx_word(rx_word)
    );

    function automatic logic [31:0] sd(int e, int s);
        return 32'hE000_0000 | (32'(e) << 8) | 32'(s);
    endfunction
    function automatic logic [WW-1:0] ent(int e);
        return {sd(e, 3), sd(e, 2), sd(e, 1), sd(e, 0)};
    endfunction
    function automatic logic [WW-1:0] upw(int k);
        return {32'hC0DE_3000 + 32'(k), 32'hC0DE_2000 + 32'(k), 32'hC0DE_1000 + 32'(k), 32'hC0DE_0000 + 32'(k)};
    endfunction
    function automatic logic [WW-1:0] rxw(int k);
        return {32'h5A00_0300 + 32'(k), 32'h5A00_0200 + 32'(k), 32'h5A00_0100 + 32'(k), 32'h5A00_0000 + 32'(k)};
    endfunction

    task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic tx_slot(bit st, logic [WW-1:0] w, logic [WW-1:0] exp, string req);
        @(negedge clk);
        tx_valid_in = 1'b1; tx_hf_start = st; tx_word_in = w;
        @(negedge clk);
        tx_valid_in = 1'b0; tx_hf_start = 1'b0;
        chk(req, {127'b0, tx_valid_out}, 128'd1);
        chk(req, tx_word_out, exp);
    endtask

    task automatic rx_slot(bit st, logic [WW-1:0] w);
        @(negedge clk);
        rx_valid = 1'b1; rx_hf_start = st; rx_word = w;
        @(negedge clk);
        rx_valid = 1'b0; rx_hf_start = 1'b0;
    endtask

    task automatic load_entry(int e, bit f);
        wr(A_PTR, 32'(e));
        wr(A_PTR, (32'(f) << 16) | 32'(e));
        flag_m[e] = f;
        for (int s = 0; s < 4; s++) begin
            wr(A_PTR, (32'(f) << 16) | (32'(s) << 8) | 32'(e));
            wr(A_TXD, sd(e, s));
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CFG, v); chk("R1 cfg reset", 128'(v), 128'h0);
        chk("R1 mode pin reset", 128'(clk_mode_slave), 128'h0);
        rd(A_PTR, v); chk("R1 pointer reset", 128'(v), 128'h0);
        wr(A_CFG, 32'h1);
        tx_slot(1'b1, upw(900), upw(900), "R1 no flag set slot0");
        tx_slot(1'b0, upw(901), upw(901), "R1 no flag set slot1");
        wr(A_CFG, 32'h0);
    endtask

    task automatic t_cfg;
        logic [31:0] v;
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v); chk("R2 cfg all ones", 128'(v), 128'h3);
        chk("R2 mode pin slave", 128'(clk_mode_slave), 128'h1);
        wr(A_CFG, 32'hFFFF_FFFC);
        rd(A_CFG, v); chk("R2 cfg cleared", 128'(v), 128'h0);
        chk("R2 mode pin master", 128'(clk_mode_slave), 128'h0);
    endtask

    task automatic t_ptr;
        logic [31:0] v;
        wr(A_PTR, 32'hFFFE_FFFF);
        rd(A_PTR, v); chk("R3 reserved bits zero", 128'(v), 128'h3FF);
        wr(A_PTR, 32'h0000_0203);
        rd(A_PTR, v); chk("R3 index/section fields", 128'(v), 128'h203);
    endtask

    task automatic t_flag;
        logic [31:0] v;
        wr(A_PTR, 32'h0001_0003);
        rd(A_PTR, v); chk("R4 same index sets flag", 128'(v), 128'h1_0003);
        wr(A_PTR, 32'h0001_0004);
        rd(A_PTR, v); chk("R4 move ignores bit16", 128'(v), 128'h4);
        wr(A_PTR, 32'h0000_0003);
        rd(A_PTR, v); chk("R4 flag kept on return", 128'(v), 128'h1_0003);
        wr(A_PTR, 32'h0000_0003);
        rd(A_PTR, v); chk("R4 same index clears flag", 128'(v), 128'h3);
    endtask

    task automatic t_txdata;
        logic [31:0] v;
        load_entry(0, 1'b1);
        load_entry(1, 1'b0);
        load_entry(2, 1'b1);
        load_entry(3, 1'b1);
        wr(A_PTR, 32'h0001_0103);
        wr(A_TXD, 32'h1234_ABCD);
        for (int s = 0; s < 4; s++) begin
            wr(A_PTR, 32'h0001_0003 | (32'(s) << 8));
            rd(A_TXD, v);
            chk($sformatf("R5 section %0d readback", s), 128'(v), 128'((s == 1) ? 32'h1234_ABCD : sd(3, s)));
        end
        wr(A_PTR, 32'h0001_0103);
        wr(A_TXD, sd(3, 1));
    endtask

    task automatic t_tx;
        for (int k = 0; k < 5; k++) begin
            tx_slot(k == 0, upw(k), upw(k), "R7 global enable off");
        end
        wr(A_CFG, 32'h1);
        for (int k = 0; k < 257; k++) begin
            int s = k % NE;
            tx_slot(k == 0, upw(k), flag_m[s] ? ent(s) : upw(k),
                    $sformatf("R6/R7/R8 slot %0d", s));
        end
        tx_slot(1'b0, upw(300), upw(300), "R8 slot1 after wrap");
        tx_slot(1'b1, upw(301), ent(0), "R8 restart to slot0");
        tx_slot(1'b0, upw(302), upw(302), "R7 flag zero slot1");
        tx_slot(1'b0, upw(303), ent(2), "R6 insert slot2");
        @(negedge clk); @(negedge clk);
        chk("R6 hold between slots", tx_word_out, ent(2));
        wr(A_CFG, 32'h0);
        tx_slot(1'b1, upw(304), upw(304), "R7 enable cleared");
    endtask

    task automatic t_rx;
        logic [31:0] v;
        rx_slot(1'b1, rxw(0));
        rx_slot(1'b0, rxw(1));
        @(negedge clk); @(negedge clk);
        rx_slot(1'b0, rxw(2));
        for (int s = 0; s < 4; s++) begin
            wr(A_PTR, (32'(s) << 8) | 32'h2);
            rd(A_RXD, v);
            chk($sformatf("R9 rx entry2 sec%0d", s), 128'(v), 128'(rxw(2)[s*32 +: 32]));
        end
        wr(A_PTR, 32'h0000_0101);
        rd(A_RXD, v); chk("R9 rx entry1 sec1", 128'(v), 128'(rxw(1)[63:32]));
        wr(A_PTR, 32'h0000_0200);
        @(negedge clk);
        bus_addr = A_RXD;
        rx_valid = 1'b1; rx_hf_start = 1'b1; rx_word = rxw(77);
        @(negedge clk);
        rx_valid = 1'b0; rx_hf_start = 1'b0;
        chk("R10 read during capture old", 128'(bus_rdata), 128'(rxw(0)[95:64]));
        @(negedge clk);
        chk("R10 next read new", 128'(bus_rdata), 128'(rxw(77)[95:64]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) flag_m[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_cfg;
        t_ptr;
        t_flag;
        t_txdata;
        t_tx;
        t_rx;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule